// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit takes a floating-point operand held in 64-bit double format and produces an estimate of its reciprocal. The estimate is rounded to single precision under a selectable rounding mode. It is then widened back to double format and returned in the low half of a 128-bit result. The upper half of that result is always zero. A lookup table indexed by the leading fraction bits seeds the estimate. One linear-interpolation step between neighbouring table entries refines it.

An operation is started by pulsing `issue` with the operand, the rounding mode and the two trap-enable bits. One clock later the unit presents the result and its class code, together with a one-cycle write strobe. In the same cycle it updates its sticky exception flags. When a trap is enabled for an exception that actually occurred, the write is withheld and the previous result and class remain on the outputs. The flags are still updated in that case. The fraction-rounded and fraction-inexact status outputs are held at zero.

Top module: `recip_est_sp`

## Requirements
- R1: Only bits [63:0] of `src_dw` form the operand. Bits [127:64] have no effect on any output.
- R2: For a normal operand whose reciprocal lies in the single normal range, the result is exactly representable in single precision: the low 29 fraction bits of the double result are zero. Its relative error against the true reciprocal is at most 1/16384.
- R3: The rounding mode encoding is 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity. On the same operand, the +infinity result is never below the -infinity result and lies at most one single ulp above it. The toward-zero result equals whichever directed result is nearer zero.
- R4: `res_we` is high exactly in the cycle after an `issue` that is not suppressed. `res_dw[127:64]` is always zero.
- R5: An operand of ±0 gives infinity of the same sign (0x7FF0000000000000 with the sign bit) and raises the zero-divide flag.
- R6: An operand of ±infinity gives zero of the same sign.
- R7: A quiet NaN gives a quiet NaN that keeps its sign and its top 23 fraction bits, with the low 29 bits cleared. A signalling NaN gives the same value with fraction bit 51 set, and raises the invalid flag.
- R8: A finite reciprocal beyond the single range raises the overflow flag. The result is then infinity when the rounding mode rounds away from zero for that sign or is nearest-even; otherwise it is the largest finite single of that sign (0x47EFFFFFE0000000 with the sign bit).
- R9: A reciprocal below 2^-126 that is not exact raises the underflow flag and is returned as a single denormal. A reciprocal that is an exact single denormal is returned exactly and raises no flag.
- R10: If the invalid trap is enabled and the operand is a signalling NaN, or the zero-divide trap is enabled and the operand is zero, then `res_we` stays low and `res_dw` and `res_class` keep their previous values. The flags are still updated.
- R11: `res_class` classifies the single result: 10001 quiet NaN, 00101/01001 +/-infinity, 00100/01000 +/-normal, 10100/11000 +/-denormal, 00010/10010 +/-zero.
- R12: `exc_flags` is [4] summary, [3] invalid signalling NaN, [2] overflow, [1] underflow, [0] zero-divide. Bits are only ever set. The summary is set on every issue that takes any of bits [3:0] from 0 to 1.
- R13: `frac_rnd` and `frac_inx` are zero in every cycle.
- R14: Reset clears `res_dw`, `res_we`, `res_class` and `exc_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start an operation this cycle |
| src_dw | input | 128 | Source register value; operand in bits [63:0] |
| rnd_mode | input | 2 | Rounding mode (0 nearest, 1 zero, 2 +inf, 3 -inf) |
| trap_inv_en | input | 1 | Invalid-operation trap enable |
| trap_zdiv_en | input | 1 | Zero-divide trap enable |
| res_dw | output | 128 | Result register value |
| res_we | output | 1 | Result write strobe |
| res_class | output | 5 | Result class code |
| exc_flags | output | 5 | Sticky exception flags and summary |
| frac_rnd | output | 1 | Fraction-rounded status |
| frac_inx | output | 1 | Fraction-inexact status |

## Verification
A behavioural model in the bench predicts the write strobe and the sticky flags on every clock. It works from the operand bits and the true reciprocal computed in real arithmetic. A design that mixed up the trap conditions would write when it should not, and a design that lost sticky bits or missed the summary edge would disagree with the model within one cycle. The bench targets the range edges. It feeds an operand whose reciprocal overflows under each rounding mode, where a wrong saturation choice shows up as infinity in place of the largest finite value. It also feeds tiny reciprocals, both inexact and exactly representable, where a faulty denormal shift or sticky bit gives a wrong value or a false underflow. Signalling NaNs, zeros with traps on and off, and pairs of operands that differ only in the upper source doubleword cover the quieting, suppression and ignored-input cases.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  typedef enum logic [2:0] {
    K_NORM, K_DENORM, K_ZERO, K_INF, K_QNAN, K_SNAN
  } op_kind_e;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_UP   = 2'd2;
  localparam logic [1:0] RM_DOWN = 2'd3;

  // 5-bit class code of a single-precision value
  function automatic logic [4:0] class_sp(input logic [31:0] v);
    logic       s;
    logic [7:0] e;
    s = v[31];
    e = v[30:23];
    if (e == 8'hFF) begin
      if (v[22:0] != 23'b0) class_sp = 5'b10001;
      else                  class_sp = s ? 5'b01001 : 5'b00101;
    end else if (e == 8'h00) begin
      if (v[22:0] == 23'b0) class_sp = s ? 5'b10010 : 5'b00010;
      else                  class_sp = s ? 5'b11000 : 5'b10100;
    end else begin
      class_sp = s ? 5'b01000 : 5'b00100;
    end
  endfunction

  // exact conversion of a single-precision value to double format
  function automatic logic [63:0] widen_sp(input logic [31:0] v);
    logic [7:0] e;
    int         p;
    e = v[30:23];
    p = 0;
    if (e == 8'hFF) begin
      widen_sp = {v[31], 11'h7FF, v[22:0], 29'b0};
    end else if (e == 8'h00) begin
      if (v[22:0] == 23'b0) begin
        widen_sp = {v[31], 63'b0};
      end else begin
        for (int k = 0; k < 23; k++) if (v[k]) p = k;
        widen_sp = {v[31], 11'(p + 874), 52'({29'b0, v[22:0]} << (52 - p))};
      end
    end else begin
      widen_sp = {v[31], 11'({3'b0, e} + 11'd896), v[22:0], 29'b0};
    end
  endfunction

endpackage

// File: rtl/recip_classify.sv
module recip_classify
  import recip_est_pkg::*;
(
  input  logic [63:0]        dbl,
  output op_kind_e           kind,
  output logic               sign,
  output logic signed [12:0] e_unb,
  output logic [51:0]        frac
);
  logic [10:0] ex;

  assign ex    = dbl[62:52];
  assign sign  = dbl[63];
  assign frac  = dbl[51:0];
  assign e_unb = $signed({2'b0, ex}) - 13'sd1023;

  always_comb begin
    if (ex == 11'h7FF) begin
      if (frac == 52'b0)  kind = K_INF;
      else if (frac[51])  kind = K_QNAN;
      else                kind = K_SNAN;
    end else if (ex == 11'h000) begin
      kind = (frac == 52'b0) ? K_ZERO : K_DENORM;
    end else begin
      kind = K_NORM;
    end
  end
endmodule

// File: rtl/recip_seed.sv
module recip_seed #(
  parameter int SEG_BITS = 7,
  parameter int FRAC_Q   = 26
) (
  input  logic [51:0]       frac,
  output logic [FRAC_Q:0]   est
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int EW   = FRAC_Q + 1;
  localparam int IB   = 52 - SEG_BITS;
  localparam int PW   = EW + IB;
  localparam int XW   = SEG_BITS + 1;
  localparam logic [63:0]   NUMER = 64'(1) << (FRAC_Q + SEG_BITS);
  localparam logic [EW-1:0] ONE   = EW'(1) << FRAC_Q;
  localparam logic [EW-1:0] HALF  = ONE >> 1;

  // reciprocal of each segment start, 1 / (1 + g/NSEG), in Q(FRAC_Q)
  logic [EW-1:0] tab [NSEG+1];
  for (genvar g = 0; g <= NSEG; g++) begin : g_tab
    localparam logic [63:0] DEN = 64'(NSEG + g);
    assign tab[g] = EW'(NUMER / DEN);
  end

  logic [XW-1:0] idx_lo, idx_hi;
  logic [IB-1:0] t;
  logic [EW-1:0] lo, hi, diff;
  logic [PW-1:0] prod;

  assign idx_lo = {1'b0, frac[51 -: SEG_BITS]};
  assign idx_hi = idx_lo + XW'(1);
  assign t      = frac[IB-1:0];
  assign lo     = tab[idx_lo];
  assign hi     = tab[idx_hi];
  assign diff   = lo - hi;
  assign prod   = PW'(diff) * PW'(t);
  assign est    = lo - EW'(prod >> IB);

  always_comb begin
    if (!$isunknown(frac)) begin
      // R2
      est_range_chk: assert (est <= ONE && est >= HALF);
    end
  end
endmodule

// File: rtl/recip_round_sp.sv
module recip_round_sp
  import recip_est_pkg::*;
#(
  parameter int SIG_W = 26
) (
  input  logic               sign,
  input  logic signed [12:0] re,
  input  logic [SIG_W-1:0]   sig,
  input  logic [1:0]         rm,
  output logic [31:0]        sp,
  output logic               ovf,
  output logic               unf
);
  localparam int PAD = 64 - SIG_W;

  logic        tiny, g, st, inexact, inc, to_inf;
  logic [5:0]  sh;
  logic [63:0] wide;
  logic [23:0] m24;
  logic [24:0] mr;
  logic [13:0] bexp;

  always_comb begin
    tiny = (re < -13'sd126);
    sh   = 6'd0;
    if (tiny) sh = (re < -13'sd166) ? 6'd40 : 6'(-13'sd126 - re);
    wide    = {sig, {PAD{1'b0}}} >> sh;
    m24     = wide[63:40];
    g       = wide[39];
    st      = |wide[38:0];
    inexact = g | st;
    case (rm)
      RM_NEAR: inc = g & (st | m24[0]);
      RM_UP:   inc = ~sign & inexact;
      RM_DOWN: inc = sign & inexact;
      default: inc = 1'b0;
    endcase
    mr   = {1'b0, m24} + {24'b0, inc};
    bexp = {re[12], re} + 14'd127 + {13'b0, mr[24]};
    ovf  = ~tiny && ($signed(bexp) >= 14'sd255);
    unf  = tiny & inexact;
    to_inf = (rm == RM_NEAR) || (rm == RM_UP && !sign) || (rm == RM_DOWN && sign);
    if (ovf)       sp = to_inf ? {sign, 8'hFF, 23'b0} : {sign, 8'hFE, 23'h7FFFFF};
    else if (tiny) sp = {sign, 7'b0, mr[23], mr[22:0]};
    else           sp = {sign, bexp[7:0], mr[24] ? 23'b0 : mr[22:0]};
  end

  always_comb begin
    if (ovf === 1'b1) begin
      // R8
      ovf_sat_chk: assert (sp[30:23] == 8'hFF || sp[30:0] == 31'h7F7FFFFF);
    end
    if (unf === 1'b1) begin
      // R9
      unf_tiny_chk: assert (sp[30:24] == 7'b0);
    end
  end
endmodule

// File: rtl/recip_est_sp.sv
module recip_est_sp
  import recip_est_pkg::*;
#(
  parameter int SEG_BITS = 7,
  parameter int FRAC_Q   = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [127:0] src_dw,
  input  logic [1:0]   rnd_mode,
  input  logic         trap_inv_en,
  input  logic         trap_zdiv_en,
  output logic [127:0] res_dw,
  output logic         res_we,
  output logic [4:0]   res_class,
  output logic [4:0]   exc_flags,
  output logic         frac_rnd,
  output logic         frac_inx
);
  op_kind_e           kind;
  logic               sign;
  logic signed [12:0] e_unb, re;
  logic [51:0]        frac;
  logic [63:0]        operand;
  logic [FRAC_Q:0]    est;
  logic [FRAC_Q-1:0]  sig;
  logic               est_is_one, finite_nz;
  logic [31:0]        sp_fin, sp_res;
  logic               ovf_raw, unf_raw;
  logic               snan_ev, zdiv_ev, ovf_ev, unf_ev, suppress_ev;
  logic [3:0]         ev_vec;
  logic [63:0]        res_lo;
  logic [3:0]         sticky;
  logic               summary;

  // the upper source doubleword is discarded by the zero mask
  assign operand = src_dw[63:0] | (src_dw[127:64] & 64'h0);

  recip_classify u_cls (
    .dbl(operand), .kind(kind), .sign(sign), .e_unb(e_unb), .frac(frac)
  );

  recip_seed #(.SEG_BITS(SEG_BITS), .FRAC_Q(FRAC_Q)) u_seed (
    .frac(frac), .est(est)
  );

  // est lies in [1/2, 1]; renormalise to [1, 2) and fold in the exponent
  assign est_is_one = est[FRAC_Q];
  assign sig        = est_is_one ? est[FRAC_Q:1] : est[FRAC_Q-1:0];
  always_comb begin
    re = -e_unb - (est_is_one ? 13'sd0 : 13'sd1);
    if (kind == K_DENORM) re = 13'sd1000;
  end

  recip_round_sp #(.SIG_W(FRAC_Q)) u_rnd (
    .sign(sign), .re(re), .sig(sig), .rm(rnd_mode),
    .sp(sp_fin), .ovf(ovf_raw), .unf(unf_raw)
  );

  always_comb begin
    case (kind)
      K_ZERO:         sp_res = {sign, 8'hFF, 23'b0};
      K_INF:          sp_res = {sign, 31'b0};
      K_QNAN, K_SNAN: sp_res = {sign, 8'hFF, 1'b1, frac[50:29]};
      default:        sp_res = sp_fin;
    endcase
  end

  assign finite_nz   = (kind == K_NORM) || (kind == K_DENORM);
  assign snan_ev     = (kind == K_SNAN);
  assign zdiv_ev     = (kind == K_ZERO);
  assign ovf_ev      = finite_nz & ovf_raw;
  assign unf_ev      = finite_nz & unf_raw;
  assign suppress_ev = (trap_inv_en & snan_ev) | (trap_zdiv_en & zdiv_ev);
  assign ev_vec      = {snan_ev, ovf_ev, unf_ev, zdiv_ev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo    <= 64'b0;
      res_we    <= 1'b0;
      res_class <= 5'b0;
      sticky    <= 4'b0;
      summary   <= 1'b0;
    end else begin
      res_we <= issue & ~suppress_ev;
      if (issue) begin
        sticky  <= sticky | ev_vec;
        summary <= summary | (|(ev_vec & ~sticky));
        if (!suppress_ev) begin
          res_lo    <= widen_sp(sp_res);
          res_class <= class_sp(sp_res);
        end
      end
    end
  end

  assign res_dw    = {64'b0, res_lo};
  assign exc_flags = {summary, sticky};
  // both status bits are left undefined by the operation; drive a fixed zero
  assign frac_rnd  = 1'b0;
  assign frac_inx  = 1'b0;

  // R4
  we_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(issue));
  // R10
  supp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && suppress_ev) |=> (!res_we && $stable(res_dw) && $stable(res_class)));
  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));
  // R12
  summary_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_flags[3:0] != $past(exc_flags[3:0])) |-> exc_flags[4]);
  // R5
  zdiv_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && zdiv_ev && !trap_zdiv_en) |=>
      (res_dw[62:0] == {11'h7FF, 52'b0} && exc_flags[0]));
endmodule

// File: tb/tb_recip_est_sp.sv
module tb_recip_est_sp;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue = 1'b0;
  logic [127:0] src_dw = '0;
  logic [1:0]   rnd_mode = 2'd0;
  logic         trap_inv_en = 1'b0;
  logic         trap_zdiv_en = 1'b0;
  logic [127:0] res_dw;
  logic         res_we;
  logic [4:0]   res_class;
  logic [4:0]   exc_flags;
  logic         frac_rnd, frac_inx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  recip_est_sp dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .src_dw(src_dw),
    .rnd_mode(rnd_mode), .trap_inv_en(trap_inv_en), .trap_zdiv_en(trap_zdiv_en),
    .res_dw(res_dw), .res_we(res_we), .res_class(res_class),
    .exc_flags(exc_flags), .frac_rnd(frac_rnd), .frac_inx(frac_inx)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  // events {invalid, overflow, underflow, zero-divide} from the operand alone
  function automatic logic [3:0] ref_events(input logic [63:0] d);
    logic [10:0] e;
    real r;
    e = d[62:52];
    ref_events = 4'b0;
    if (e == 11'h7FF) begin
      ref_events[3] = (d[51:0] != 0) && !d[51];
    end else if (e == 11'h0 && d[51:0] == 0) begin
      ref_events[0] = 1'b1;
    end else begin
      r = absr(1.0 / $bitstoreal(d));
      ref_events[2] = (r >= 2.0 ** 128);
      ref_events[1] = (r < 2.0 ** -126) && ((d[51:0] != 0) || (r < 2.0 ** -149));
    end
  endfunction

  function automatic logic [4:0] ref_class(input logic [63:0] d);
    real a;
    if (d[62:52] == 11'h7FF) return (d[51:0] != 0) ? 5'b10001 : (d[63] ? 5'b01001 : 5'b00101);
    a = absr($bitstoreal(d));
    if (a == 0.0)          return d[63] ? 5'b10010 : 5'b00010;
    if (a < 2.0 ** -126)   return d[63] ? 5'b11000 : 5'b10100;
    return d[63] ? 5'b01000 : 5'b00100;
  endfunction

  // cycle model of write strobe and sticky flags
  logic [4:0] m_flags;
  logic       m_we;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags <= 5'b0;
      m_we    <= 1'b0;
    end else begin
      logic [3:0] ev;
      ev = ref_events(src_dw[63:0]);
      m_we <= issue && !(trap_inv_en && ev[3]) && !(trap_zdiv_en && ev[0]);
      if (issue)
        m_flags <= {m_flags[4] | (|(ev & ~m_flags[3:0])), m_flags[3:0] | ev};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(res_we == m_we, "R4 write strobe", 64'(res_we), 64'(m_we));
      chk(exc_flags == m_flags, "R12 sticky flags", 64'(exc_flags), 64'(m_flags));
      chk(res_dw[127:64] == 64'b0, "R4 upper doubleword", res_dw[127:64], 64'b0);
      chk(!frac_rnd && !frac_inx, "R13 status bits", {62'b0, frac_rnd, frac_inx}, 64'b0);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    issue = 1'b0;
    repeat (2) @(negedge clk);
    chk(res_dw == 128'b0 && !res_we && res_class == 5'b0 && exc_flags == 5'b0,
        "R14 reset state", {res_dw[31:0], 22'b0, res_we, res_class, exc_flags}, 64'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_op(input logic [63:0] hi, input logic [63:0] lo, input logic [1:0] rm,
                        input logic ve, input logic ze, output logic [63:0] r);
    @(negedge clk);
    src_dw = {hi, lo};
    rnd_mode = rm;
    trap_inv_en = ve;
    trap_zdiv_en = ze;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    r = res_dw[63:0];
  endtask

  // op that writes: check value and class
  task automatic op_exact(input string tag, input logic [63:0] x, input logic [1:0] rm,
                          input logic [63:0] exp);
    logic [63:0] r;
    run_op(64'h0, x, rm, 1'b0, 1'b0, r);
    chk(r == exp, tag, r, exp);
    chk(res_class == ref_class(exp), "R11 class", 64'(res_class), 64'(ref_class(exp)));
  endtask

  initial begin
    logic [63:0] r, r2, rp, rn, rm_, rz, prev;
    logic [4:0]  pc;
    real         xv, ex, got, err;
    logic [63:0] tests [4];

    do_reset();

    // R2 / R1: random normal operands with in-range reciprocals
    for (int i = 0; i < 300; i++) begin
      logic [63:0] x;
      logic [63:0] hi;
      logic [1:0]  m;
      x  = {1'($urandom()), 11'(923 + $urandom_range(0, 200)), 20'($urandom()), 32'($urandom())};
      hi = {$urandom(), $urandom()};
      m  = 2'($urandom());
      run_op(hi, x, m, 1'b0, 1'b0, r);
      xv  = $bitstoreal(x);
      ex  = 1.0 / xv;
      got = $bitstoreal(r);
      err = absr((got - ex) / ex);
      chk(err <= 1.0 / 16384.0, "R2 relative error", r, $realtobits(ex));
      chk(r[28:0] == 29'b0, "R2 single representable", r, r & ~64'h1FFFFFFF);
      chk(res_class == ref_class(r), "R11 normal class", 64'(res_class), 64'(ref_class(r)));
      if (i < 30) begin
        run_op(~hi, x, m, 1'b0, 1'b0, r2);
        chk(r2 == r, "R1 upper source ignored", r2, r);
      end
    end

    // R3: directed rounding relations
    tests[0] = 64'h4008000000000000;  // 3.0
    tests[1] = 64'hC008000000000000;  // -3.0
    tests[2] = 64'h3FF5555555555555;
    tests[3] = 64'hC11C71C71C71C71C;
    foreach (tests[k]) begin
      run_op(64'h0, tests[k], 2'd0, 1'b0, 1'b0, rn);
      run_op(64'h0, tests[k], 2'd1, 1'b0, 1'b0, rz);
      run_op(64'h0, tests[k], 2'd2, 1'b0, 1'b0, rp);
      run_op(64'h0, tests[k], 2'd3, 1'b0, 1'b0, rm_);
      chk($bitstoreal(rp) >= $bitstoreal(rn) && $bitstoreal(rn) >= $bitstoreal(rm_),
          "R3 mode ordering", rp, rm_);
      chk(rz == (tests[k][63] ? rp : rm_), "R3 toward zero", rz, tests[k][63] ? rp : rm_);
      chk(((tests[k][63] ? (rm_ - rp) : (rp - rm_)) <= 64'h20000000), "R3 one ulp apart", rp, rm_);
    end

    // R5 / R6 / R7 / R11 specials
    op_exact("R5 +0 to +inf", 64'h0000000000000000, 2'd0, 64'h7FF0000000000000);
    chk(exc_flags[0], "R5 zero-divide flag", 64'(exc_flags), 64'h1);
    op_exact("R5 -0 to -inf", 64'h8000000000000000, 2'd1, 64'hFFF0000000000000);
    op_exact("R6 +inf to +0", 64'h7FF0000000000000, 2'd0, 64'h0);
    op_exact("R6 -inf to -0", 64'hFFF0000000000000, 2'd3, 64'h8000000000000000);
    op_exact("R7 quiet NaN", 64'h7FF8000012345678, 2'd0, 64'h7FF8000000000000);
    op_exact("R7 neg quiet NaN", 64'hFFFC00ABCDE00001, 2'd2, 64'hFFFC00ABC0000000);
    op_exact("R7 signalling NaN", 64'h7FF0000080000000, 2'd0, 64'h7FF8000080000000);
    chk(exc_flags[3], "R7 invalid flag", 64'(exc_flags), 64'h8);

    // R8 overflow under each mode
    do_reset();
    op_exact("R8 nearest", 64'h3730000000000000, 2'd0, 64'h7FF0000000000000);
    chk(exc_flags[2], "R8 overflow flag", 64'(exc_flags), 64'h4);
    op_exact("R8 toward zero", 64'h3730000000000000, 2'd1, 64'h47EFFFFFE0000000);
    op_exact("R8 up positive", 64'h3730000000000000, 2'd2, 64'h7FF0000000000000);
    op_exact("R8 down positive", 64'h3730000000000000, 2'd3, 64'h47EFFFFFE0000000);
    op_exact("R8 down negative", 64'hB730000000000000, 2'd3, 64'hFFF0000000000000);
    op_exact("R8 up negative", 64'hB730000000000000, 2'd2, 64'hC7EFFFFFE0000000);
    op_exact("R8 double denormal", 64'h0000000000000001, 2'd0, 64'h7FF0000000000000);

    // R9 underflow
    do_reset();
    op_exact("R9 exact tiny", 64'h48B0000000000000, 2'd0, 64'h3730000000000000);
    chk(exc_flags == 5'b0, "R9 no flag when exact", 64'(exc_flags), 64'h0);
    foreach (tests[k]) begin
      logic [63:0] x;
      x = {k[0], 63'h4898000000000000};
      run_op(64'h0, x, 2'(k), 1'b0, 1'b0, r);
      ex  = 1.0 / $bitstoreal(x);
      got = $bitstoreal(r);
      chk(absr(got - ex) <= 2.0 ** -149 + absr(ex) / 16384.0, "R9 denormal value", r, $realtobits(ex));
      chk(res_class == (k[0] ? 5'b11000 : 5'b10100), "R11 denormal class",
          64'(res_class), k[0] ? 64'h18 : 64'h14);
    end
    chk(exc_flags[1], "R9 underflow flag", 64'(exc_flags), 64'h2);

    // R10 suppression, R12 flag sequence
    do_reset();
    op_exact("R10 setup", 64'h4000000000000000, 2'd0, 64'h3FE0000000000000);
    prev = res_dw[63:0];
    pc   = res_class;
    run_op(64'h0, 64'h7FF4000000000000, 2'd0, 1'b1, 1'b0, r);
    chk(r == prev && res_class == pc, "R10 invalid trap holds result", r, prev);
    chk(exc_flags == 5'b11000, "R12 invalid sets summary", 64'(exc_flags), 64'h18);
    run_op(64'h0, 64'h8000000000000000, 2'd0, 1'b0, 1'b1, r);
    chk(r == prev && res_class == pc, "R10 zero-divide trap holds result", r, prev);
    chk(exc_flags == 5'b11001, "R12 zero-divide adds flag", 64'(exc_flags), 64'h19);
    run_op(64'h0, 64'h7FF4000000000000, 2'd0, 1'b0, 1'b1, r);
    chk(r == 64'h7FFC000000000000, "R10 other trap does not suppress", r, 64'h7FFC000000000000);
    run_op(64'h0, 64'h0000000000000000, 2'd0, 1'b1, 1'b0, r);
    chk(r == 64'h7FF0000000000000, "R10 zero with only invalid trap writes", r, 64'h7FF0000000000000);
    chk(exc_flags == 5'b11001, "R12 flags only set", 64'(exc_flags), 64'h19);

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule